// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Zero Suppression

This block turns binary-coded decimal digits into drive patterns for seven-segment displays. The outputs are active low. Each digit goes through its own decoder cell. A cell has three controls: a lamp-test input, a forced-blank input and a ripple-blank pair. The ripple pair is split into a separate incoming line and a separate outgoing line, so the block has no bidirectional pin. The block is purely combinational. It has no clock and no state, and its outputs follow the inputs directly.

The top module wraps a row of cells and links their ripple lines into a chain. In the default leading mode, the chain starts at the most significant digit and moves toward less significant digits. Zeros in front of the first nonzero digit go dark, and any zero after a nonzero digit stays lit. A parameter reverses the chain so that it starts at digit 0 and moves upward, for suppressing trailing zeros after a decimal point. The chain's input and output both appear on the ports, so rows can be cascaded. The data is plain combinational control with no flow control, so there is no valid/ready handshake and no back-pressure.

Top module: `bcd7_display`

## Requirements
- R1: Digit i takes its value from `digits_i[4i+3:4i]`, and digit 0 is the least significant. Its segment drives are `seg_n_o[7i+6:7i]`, with bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f and bit 6 = g. A segment is lit when its bit is 0.
- R2: These are the lit segments for each value when the digit is not blanked and lamp test is inactive:
  - 0: a b c d e f
  - 1: b c
  - 2: a b d e g
  - 3: a b c d g
  - 4: b c f g
  - 5: a c d f g
  - 6: a c d e f g
  - 7: a b c
  - 8: all seven
  - 9: a b c d f g
- R3: Values 10 to 15 light only segment g, which shows a dash.
- R4: When `lamp_test_n` is low, every segment of every digit is lit. This overrides the digit values and ripple blanking, and `ripple_out_n` is high.
- R5: When `force_blank_n` is low, every digit is dark. This overrides lamp test, and `ripple_out_n` is low.
- R6: A cell goes dark and drives its outgoing ripple line low when all of these hold: its value is 0, its incoming ripple line is low, lamp test is inactive and forced blank is inactive. In every other case with forced blank inactive, its outgoing ripple line is high.
- R7: In leading mode (`TRAIL_MODE` = 0), `ripple_in_n` feeds the most significant digit, and each digit's outgoing line feeds the next less significant digit. `ripple_out_n` is the outgoing line of digit 0. For example, 0070 shows as dark, dark, 7, 0.
- R8: When `ripple_in_n` is high, no digit is ripple-blanked, so all zeros are shown.
- R9: In trailing mode (`TRAIL_MODE` = 1), `ripple_in_n` feeds digit 0, and each digit's outgoing line feeds the next more significant digit. `ripple_out_n` is the outgoing line of the most significant digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digits_i | input | 4*NUM_DIGITS | Packed BCD digits, digit 0 in the low nibble |
| lamp_test_n | input | 1 | Active-low lamp test, lights all segments |
| force_blank_n | input | 1 | Active-low forced blank for the whole row |
| ripple_in_n | input | 1 | Ripple-blank input to the first digit of the chain |
| seg_n_o | output | 7*NUM_DIGITS | Active-low segment drives, 7 bits per digit |
| ripple_out_n | output | 1 | Ripple-blank output of the last digit of the chain |

## Verification
The bench targets zeros that sit after a nonzero digit, as in 0506 and 9800. A chain that failed to release would blank these zeros and lose significant digits. It drives the all-zero row and checks that the ripple output falls, and it checks a nonzero code above 9 in a leading position to confirm that the code stops the chain. Priority clashes are applied directly: lamp test against ripple blanking, and forced blank against lamp test. A wrong priority order would show either a lit row that should be dark or a dark row during a lamp test. A second instance in trailing mode runs the chain in the reverse direction. A fixed chain direction would blank the wrong end of the number.

// File: rtl/bcd7_pkg.sv
`timescale 1ns/1ps
package bcd7_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;
  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_NONE = '0;
  localparam seg_t SEG_DASH = 7'h40;
endpackage

// File: rtl/bcd7_glyph.sv
`timescale 1ns/1ps
module bcd7_glyph
  import bcd7_pkg::*;
(
  input  bcd_t value_i,
  output seg_t lit_o   // active high, bit0 = a .. bit6 = g
);
  always_comb begin
    unique case (value_i)
      4'd0:    lit_o = 7'h3F;
      4'd1:    lit_o = 7'h06;
      4'd2:    lit_o = 7'h5B;
      4'd3:    lit_o = 7'h4F;
      4'd4:    lit_o = 7'h66;
      4'd5:    lit_o = 7'h6D;
      4'd6:    lit_o = 7'h7D;
      4'd7:    lit_o = 7'h07;
      4'd8:    lit_o = 7'h7F;
      4'd9:    lit_o = 7'h6F;
      default: lit_o = SEG_DASH;
    endcase
  end
endmodule

// File: rtl/bcd7_blank.sv
`timescale 1ns/1ps
module bcd7_blank
  import bcd7_pkg::*;
(
  input  bcd_t value_i,
  input  logic lamp_test_n,
  input  logic force_blank_n,
  input  logic rip_in_n,
  output logic dark_o,
  output logic rip_out_n
);
  logic is_zero;
  logic rip_kill;

  assign is_zero   = (value_i == '0);
  assign rip_kill  = is_zero & ~rip_in_n & lamp_test_n;
  assign dark_o    = ~force_blank_n | rip_kill;
  assign rip_out_n = force_blank_n & ~rip_kill;
endmodule

// File: rtl/bcd7_cell.sv
`timescale 1ns/1ps
module bcd7_cell
  import bcd7_pkg::*;
(
  input  bcd_t value_i,
  input  logic lamp_test_n,
  input  logic force_blank_n,
  input  logic rip_in_n,
  output seg_t seg_n_o,
  output logic rip_out_n
);
  seg_t glyph;
  logic dark;

  bcd7_glyph u_glyph (
    .value_i (value_i),
    .lit_o   (glyph)
  );

  bcd7_blank u_blank (
    .value_i       (value_i),
    .lamp_test_n   (lamp_test_n),
    .force_blank_n (force_blank_n),
    .rip_in_n      (rip_in_n),
    .dark_o        (dark),
    .rip_out_n     (rip_out_n)
  );

  // priority: forced blank, then lamp test, then ripple blank, then glyph
  always_comb begin
    if (!force_blank_n)    seg_n_o = ~SEG_NONE;
    else if (!lamp_test_n) seg_n_o = SEG_NONE;
    else if (dark)         seg_n_o = ~SEG_NONE;
    else                   seg_n_o = ~glyph;
  end

  always_comb begin
    assert_force_dark_R5: assert final (force_blank_n || (seg_n_o == ~SEG_NONE && !rip_out_n))
      else $error("forced blank not dark");
    assert_lamp_full_R4: assert final (!force_blank_n || lamp_test_n || (seg_n_o == SEG_NONE && rip_out_n))
      else $error("lamp test not full");
    assert_ripple_dark_R6: assert final (!force_blank_n || rip_out_n ||
                                         (value_i == '0 && !rip_in_n && seg_n_o == ~SEG_NONE))
      else $error("ripple low without blank zero");
    assert_over_nine_R3: assert final (!force_blank_n || !lamp_test_n || value_i < 4'd10 ||
                                       seg_n_o == ~SEG_DASH)
      else $error("code above nine not dash");
  end
endmodule

// File: rtl/bcd7_display.sv
`timescale 1ns/1ps
module bcd7_display
  import bcd7_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int TRAIL_MODE = 0
) (
  input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
  input  logic                        lamp_test_n,
  input  logic                        force_blank_n,
  input  logic                        ripple_in_n,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_n_o,
  output logic                        ripple_out_n
);
  localparam int LAST = NUM_DIGITS - 1;

  logic chain [NUM_DIGITS+1];

  assign chain[0]     = ripple_in_n;
  assign ripple_out_n = chain[NUM_DIGITS];

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_link
    // k is the chain position, P the digit it serves
    localparam int P = (TRAIL_MODE != 0) ? k : LAST - k;

    bcd7_cell u_cell (
      .value_i       (digits_i[P*BCD_W +: BCD_W]),
      .lamp_test_n   (lamp_test_n),
      .force_blank_n (force_blank_n),
      .rip_in_n      (chain[k]),
      .seg_n_o       (seg_n_o[P*SEG_W +: SEG_W]),
      .rip_out_n     (chain[k+1])
    );

    always_comb begin
      assert_chain_hold_R7: assert final (!force_blank_n || !chain[k] || chain[k+1])
        else $error("chain fell after release");
      assert_nonzero_pass_R6: assert final (!force_blank_n || digits_i[P*BCD_W +: BCD_W] == '0 ||
                                            chain[k+1])
        else $error("nonzero digit kept chain low");
    end
  end
endmodule

// File: tb/bcd7_display_tb.sv
`timescale 1ns/1ps
module bcd7_display_tb;
  localparam int N  = 4;
  localparam int NV = 13;
  localparam logic [3:0] BL = 4'd11;  // dark digit
  localparam logic [3:0] DS = 4'd10;  // dash
  localparam logic [3:0] AL = 4'd12;  // all lit

  // [35:20] digits, [19:17] lamp_n blank_n rip_n, [16:1] s3..s0, [0] rip out
  localparam logic [35:0] VEC [NV] = '{
    {16'h0070, 3'b110, BL, BL, 4'd7, 4'd0, 1'b1},
    {16'h1234, 3'b110, 4'd1, 4'd2, 4'd3, 4'd4, 1'b1},
    {16'h0000, 3'b110, BL, BL, BL, BL, 1'b0},
    {16'h0005, 3'b110, BL, BL, BL, 4'd5, 1'b1},
    {16'h0506, 3'b110, BL, 4'd5, 4'd0, 4'd6, 1'b1},
    {16'h9800, 3'b110, 4'd9, 4'd8, 4'd0, 4'd0, 1'b1},
    {16'h00A0, 3'b110, BL, BL, DS, 4'd0, 1'b1},
    {16'h0070, 3'b111, 4'd0, 4'd0, 4'd7, 4'd0, 1'b1},
    {16'h0000, 3'b010, AL, AL, AL, AL, 1'b1},
    {16'h1234, 3'b100, BL, BL, BL, BL, 1'b0},
    {16'h0000, 3'b000, BL, BL, BL, BL, 1'b0},
    {16'hFEDC, 3'b110, DS, DS, DS, DS, 1'b1},
    {16'h6789, 3'b110, 4'd6, 4'd7, 4'd8, 4'd9, 1'b1}
  };
  localparam string TAG [NV] = '{"R7", "R1 R2", "R6", "R7", "R7", "R7 R2", "R3",
                                 "R8", "R4", "R5", "R5", "R3", "R2"};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst = 1'b1;

  logic [N*4-1:0] digits, t_digits;
  logic lt_n, bi_n, rbi_n, t_rbi_n;
  logic [N*7-1:0] seg_n, t_seg_n;
  logic rbo_n, t_rbo_n;
  int checks = 0;
  int errors = 0;

  bcd7_display #(.NUM_DIGITS(N), .TRAIL_MODE(0)) u_dut (
    .digits_i (digits), .lamp_test_n (lt_n), .force_blank_n (bi_n),
    .ripple_in_n (rbi_n), .seg_n_o (seg_n), .ripple_out_n (rbo_n));

  bcd7_display #(.NUM_DIGITS(N), .TRAIL_MODE(1)) u_trl (
    .digits_i (t_digits), .lamp_test_n (1'b1), .force_blank_n (1'b1),
    .ripple_in_n (t_rbi_n), .seg_n_o (t_seg_n), .ripple_out_n (t_rbo_n));

  function automatic logic [6:0] sym_seg(logic [3:0] s);
    case (s)
      4'd0: return ~7'h3F;  4'd1: return ~7'h06;  4'd2: return ~7'h5B;
      4'd3: return ~7'h4F;  4'd4: return ~7'h66;  4'd5: return ~7'h6D;
      4'd6: return ~7'h7D;  4'd7: return ~7'h07;  4'd8: return ~7'h7F;
      4'd9: return ~7'h6F;  4'd10: return ~7'h40; 4'd12: return 7'h00;
      default: return 7'h7F;
    endcase
  endfunction

  function automatic logic [27:0] row_seg(logic [15:0] syms);
    logic [27:0] r;
    for (int d = 0; d < N; d++) r[7*d +: 7] = sym_seg(syms[4*d +: 4]);
    return r;
  endfunction

  task automatic check(string req, logic [27:0] got, logic [27:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    digits = '0; lt_n = 1'b1; bi_n = 1'b1; rbi_n = 1'b0;
    t_digits = '0; t_rbi_n = 1'b0;
    repeat (3) @(negedge clk);
    // idle state under reset: all-zero row with ripple active is dark (R6)
    check("R6 idle", seg_n, {28{1'b1}});
    check("R6 idle ripple", {27'd0, rbo_n}, 28'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      digits = VEC[i][35:20];
      {lt_n, bi_n, rbi_n} = VEC[i][19:17];
      @(negedge clk);
      check(TAG[i], seg_n, row_seg(VEC[i][16:1]));
      check({TAG[i], " ripple"}, {27'd0, rbo_n}, {27'd0, VEC[i][0]});
    end

    // trailing mode: chain enters at digit 0 (R9)
    @(posedge clk); t_digits = 16'h7000; t_rbi_n = 1'b0;
    @(negedge clk);
    check("R9 7000", t_seg_n, row_seg({4'd7, BL, BL, BL}));
    check("R9 7000 ripple", {27'd0, t_rbo_n}, 28'd1);
    @(posedge clk); t_digits = 16'h0500;
    @(negedge clk);
    check("R9 0500", t_seg_n, row_seg({4'd0, 4'd5, BL, BL}));
    @(posedge clk); t_digits = 16'h0000;
    @(negedge clk);
    check("R9 0000", t_seg_n, row_seg({BL, BL, BL, BL}));
    check("R9 0000 ripple", {27'd0, t_rbo_n}, 28'd0);
    @(posedge clk); t_rbi_n = 1'b1;
    @(negedge clk);
    check("R8 R9 released", t_seg_n, row_seg({4'd0, 4'd0, 4'd0, 4'd0}));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule